// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for one agent on a 32-bit multiplexed address/data bus with a 4-bit command/byte-enable field. When the agent sources an address or data phase, the block sends out the matching parity bit one clock later, together with an output-enable for that bit. When the agent accepts an address or data phase, the block recomputes parity from the captured bus values. It then compares the result with the parity bit that arrives on the following clock.

A detected mismatch sets a sticky status bit. Software clears that bit by writing a one. A mismatch on a data phase also drives an active-low error strobe for one clock, but only when the response-enable bit from the command register is set. A mismatch on an address phase sets the status bit and never drives the strobe. A single balanced XOR tree serves both directions, because in any given cycle the agent either drives the bus or samples it.

Top module: `pci_parity_unit`

## Requirements
- R1: After reset, par_oe_o and par_o are 0, perr_n_o is 1 and det_perr_o is 0.
- R2: When src_valid_i is high at a rising edge, par_oe_o is 1 after that edge. par_o then equals the XOR of ad_i[31:0] and cbe_i[3:0] captured at that edge, so the 37 bits together hold an even number of ones.
- R3: When src_valid_i is low at a rising edge, par_oe_o and par_o are both 0 after that edge.
- R4: A phase flagged by rcv_addr_i or rcv_data_i at edge k is checked against par_i at edge k+1. A mismatch makes det_perr_o 1 after edge k+1.
- R5: A data-phase mismatch (rcv_data_i high at edge k) with perr_resp_en_i high at edge k+1 drives perr_n_o low after edge k+1, for exactly one clock.
- R6: A data-phase mismatch with perr_resp_en_i low at edge k+1 leaves perr_n_o high but still sets det_perr_o.
- R7: An address-phase mismatch (rcv_addr_i high, rcv_data_i low) sets det_perr_o and leaves perr_n_o high. If both flags are high, the phase counts as a data phase.
- R8: det_perr_o stays 1 until stat_clr_i is high at an edge, and it reads 0 after that edge. If a new mismatch is detected at the same edge, the bit stays 1.
- R9: A matching parity bit, or a wrong par_i with neither receive flag set on the previous edge, changes neither det_perr_o nor perr_n_o.
- R10: Bad data phases on consecutive edges give perr_n_o low on consecutive clocks, one clock per phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus value for the current cycle |
| cbe_i | input | 4 | Command/byte-enable value for the current cycle |
| src_valid_i | input | 1 | Agent sources an address or data phase this cycle |
| rcv_addr_i | input | 1 | Agent accepts an address phase this cycle |
| rcv_data_i | input | 1 | Agent accepts a data phase this cycle |
| par_i | input | 1 | Parity bit sampled from the bus |
| perr_resp_en_i | input | 1 | Command-register parity-error response enable |
| stat_clr_i | input | 1 | Write-one-to-clear strobe for the status bit |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for par_o |
| perr_n_o | output | 1 | Active-low data parity error strobe |
| det_perr_o | output | 1 | Sticky detected-parity-error status |

## Verification
The generated parity is due one rising edge after the sourced phase. The status bit and the error strobe are due one edge after par_i is sampled, which is the second edge after the received phase. The bench drives every input on the falling edge and samples outputs on the next falling edge after the relevant rising edge. It checks the strobe again one clock later to confirm that the pulse lasts one cycle. Its expected parity comes from counting bits in a loop rather than from an XOR reduction.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } rcv_kind_t;

    typedef struct packed {
        logic par;
        logic oe;
    } gen_st_t;

    typedef struct packed {
        rcv_kind_t kind;
        logic      exp_par;
        logic      det;
        logic      perr_n;
    } chk_st_t;

endpackage

// File: rtl/pci_par_tree.sv
module pci_par_tree #(
    parameter int W = 36
) (
    input  logic [W-1:0] bits_i,
    output logic         par_o
);
    localparam int LV = (W > 1) ? $clog2(W) : 1;
    localparam int NP = 1 << LV;

    // heap layout: node 0 is the root, leaves start at NP-1
    logic [2*NP-2:0] node;

    for (genvar i = 0; i < NP; i++) begin : g_leaf
        if (i < W) begin : g_used
            assign node[NP-1+i] = bits_i[i];
        end else begin : g_pad
            assign node[NP-1+i] = 1'b0;
        end
    end

    for (genvar i = 0; i < NP-1; i++) begin : g_node
        assign node[i] = node[2*i+1] ^ node[2*i+2];
    end

    assign par_o = node[0];

endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen
    import pci_par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_valid_i,
    input  logic par_calc_i,
    output logic par_o,
    output logic par_oe_o
);
    gen_st_t d, q;

    always_comb begin
        d     = q;
        d.oe  = src_valid_i;
        d.par = src_valid_i ? par_calc_i : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign par_o    = q.par;
    assign par_oe_o = q.oe;

    // R3: no sourced phase leaves the parity pin undriven and low
    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !src_valid_i |=> (!par_oe_o && !par_o));

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
    import pci_par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rcv_addr_i,
    input  logic rcv_data_i,
    input  logic par_calc_i,
    input  logic par_i,
    input  logic resp_en_i,
    input  logic stat_clr_i,
    output logic det_o,
    output logic perr_n_o
);
    chk_st_t d, q;
    logic    mismatch;

    always_comb begin
        mismatch  = (q.kind != PH_NONE) && (q.exp_par != par_i);
        d         = q;
        d.exp_par = par_calc_i;
        if (rcv_data_i)      d.kind = PH_DATA;
        else if (rcv_addr_i) d.kind = PH_ADDR;
        else                 d.kind = PH_NONE;
        d.perr_n  = !(mismatch && (q.kind == PH_DATA) && resp_en_i);
        if (mismatch)        d.det = 1'b1;
        else if (stat_clr_i) d.det = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.perr_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign det_o    = q.det;
    assign perr_n_o = q.perr_n;

    // R8: status holds without a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (det_o && !stat_clr_i) |=> det_o);

    // R8: clear with no concurrent error empties the status
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_i && !mismatch) |=> !det_o);

    // R5: the strobe never fires without the status bit
    a_r5_perr_implies_det: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n_o |-> det_o);

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_i,
    input  logic             src_valid_i,
    input  logic             rcv_addr_i,
    input  logic             rcv_data_i,
    input  logic             par_i,
    input  logic             perr_resp_en_i,
    input  logic             stat_clr_i,
    output logic             par_o,
    output logic             par_oe_o,
    output logic             perr_n_o,
    output logic             det_perr_o
);
    localparam int BUS_W = AD_W + CBE_W;

    logic [BUS_W-1:0] bus_bits;
    logic             par_calc;

    assign bus_bits = {cbe_i, ad_i};

    pci_par_tree #(.W(BUS_W)) u_tree (
        .bits_i (bus_bits),
        .par_o  (par_calc)
    );

    pci_par_gen u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_valid_i (src_valid_i),
        .par_calc_i  (par_calc),
        .par_o       (par_o),
        .par_oe_o    (par_oe_o)
    );

    pci_par_chk u_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .rcv_addr_i (rcv_addr_i),
        .rcv_data_i (rcv_data_i),
        .par_calc_i (par_calc),
        .par_i      (par_i),
        .resp_en_i  (perr_resp_en_i),
        .stat_clr_i (stat_clr_i),
        .det_o      (det_perr_o),
        .perr_n_o   (perr_n_o)
    );

    // R2: driven parity makes the sourced phase even
    a_r2_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        src_valid_i |=> (par_oe_o && ((^$past(bus_bits)) == par_o)));

    // R7: an address phase alone never drives the strobe two edges on
    a_r7_addr_no_perr: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_addr_i && !rcv_data_i) |=> ##1 perr_n_o);

endmodule

// File: tb/pci_parity_unit_tb_top.sv
module pci_parity_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        src_valid_i = 1'b0;
    logic        rcv_addr_i = 1'b0;
    logic        rcv_data_i = 1'b0;
    logic        par_i = 1'b0;
    logic        perr_resp_en_i = 1'b0;
    logic        stat_clr_i = 1'b0;
    logic        par_o, par_oe_o, perr_n_o, det_perr_o;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_parity_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i),
        .src_valid_i(src_valid_i), .rcv_addr_i(rcv_addr_i),
        .rcv_data_i(rcv_data_i), .par_i(par_i),
        .perr_resp_en_i(perr_resp_en_i), .stat_clr_i(stat_clr_i),
        .par_o(par_o), .par_oe_o(par_oe_o), .perr_n_o(perr_n_o),
        .det_perr_o(det_perr_o)
    );

    function automatic logic ref_par(input logic [31:0] a, input logic [3:0] c);
        int n = 0;
        for (int i = 0; i < 32; i++) n += a[i];
        for (int i = 0; i < 4; i++) n += c[i];
        return logic'(n % 2);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_status();
        stat_clr_i = 1'b1;
        tick();
        stat_clr_i = 1'b0;
        chk("R8 clear", det_perr_o, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 par_oe", par_oe_o, 1'b0);
        chk("R1 par", par_o, 1'b0);
        chk("R1 perr_n", perr_n_o, 1'b1);
        chk("R1 det", det_perr_o, 1'b0);
    endtask

    task automatic t_source();
        logic [31:0] a [6];
        logic [3:0]  c [6];
        a[0] = 32'h0;         c[0] = 4'h0;
        a[1] = 32'h1;         c[1] = 4'h0;
        a[2] = 32'hFFFF_FFFF; c[2] = 4'hF;
        a[3] = 32'h8000_0000; c[3] = 4'h7;
        a[4] = 32'hDEAD_BEEF; c[4] = 4'h6;
        a[5] = 32'h1234_5671; c[5] = 4'h1;
        // back-to-back sourced phases
        for (int i = 0; i < 6; i++) begin
            src_valid_i = 1'b1; ad_i = a[i]; cbe_i = c[i];
            tick();
            chk("R2 oe", par_oe_o, 1'b1);
            chk("R2 parity", par_o, ref_par(a[i], c[i]));
        end
        src_valid_i = 1'b0; ad_i = 32'hFFFF_FFFE; cbe_i = 4'h0;
        tick();
        chk("R3 idle oe", par_oe_o, 1'b0);
        chk("R3 idle par", par_o, 1'b0);
    endtask

    // one received phase; bad flips the parity bit presented next cycle
    task automatic rcv_phase(input bit is_addr, input bit is_data,
                             input logic [31:0] a, input logic [3:0] c,
                             input bit bad, input bit en,
                             input logic exp_det, input logic exp_perr_n,
                             input string req);
        rcv_addr_i = is_addr; rcv_data_i = is_data; ad_i = a; cbe_i = c;
        tick();
        rcv_addr_i = 1'b0; rcv_data_i = 1'b0; ad_i = ~a;
        par_i = ref_par(a, c) ^ bad; perr_resp_en_i = en;
        tick();
        chk({req, " det"}, det_perr_o, exp_det);
        chk({req, " perr_n"}, perr_n_o, exp_perr_n);
        par_i = 1'b0;
        tick();
        chk({req, " perr_n after"}, perr_n_o, 1'b1);
    endtask

    task automatic t_receive_good();
        rcv_phase(1, 0, 32'hCAFE_0001, 4'h6, 0, 1, 1'b0, 1'b1, "R9 good addr");
        rcv_phase(0, 1, 32'h0F0F_0F0F, 4'hA, 0, 1, 1'b0, 1'b1, "R9 good data");
        // wrong parity with no receive flag
        par_i = 1'b1; tick(); par_i = 1'b0; tick();
        chk("R9 unflagged det", det_perr_o, 1'b0);
        chk("R9 unflagged perr_n", perr_n_o, 1'b1);
    endtask

    task automatic t_data_err();
        rcv_phase(0, 1, 32'h5555_AAAA, 4'h3, 1, 1, 1'b1, 1'b0, "R5 data bad en");
        clear_status();
        rcv_phase(0, 1, 32'h0000_0101, 4'h8, 1, 0, 1'b1, 1'b1, "R6 data bad dis");
        clear_status();
    endtask

    task automatic t_addr_err();
        rcv_phase(1, 0, 32'h0000_1000, 4'h7, 1, 1, 1'b1, 1'b1, "R7 addr bad");
        clear_status();
        rcv_phase(1, 1, 32'h0000_1000, 4'h7, 1, 1, 1'b1, 1'b0, "R7 both flags");
        clear_status();
    endtask

    task automatic t_sticky();
        rcv_phase(0, 1, 32'h1, 4'h0, 1, 0, 1'b1, 1'b1, "R4 set");
        repeat (3) tick();
        chk("R8 sticky", det_perr_o, 1'b1);
        rcv_phase(0, 1, 32'h2, 4'h0, 0, 0, 1'b1, 1'b1, "R8 good keeps");
        clear_status();
        // clear coinciding with a new error: error wins
        rcv_data_i = 1'b1; ad_i = 32'h3; cbe_i = 4'h0;
        tick();
        rcv_data_i = 1'b0; par_i = ~ref_par(32'h3, 4'h0); perr_resp_en_i = 1'b0;
        stat_clr_i = 1'b1;
        tick();
        stat_clr_i = 1'b0; par_i = 1'b0;
        chk("R8 set beats clear", det_perr_o, 1'b1);
        clear_status();
    endtask

    task automatic t_back_to_back();
        perr_resp_en_i = 1'b1;
        rcv_data_i = 1'b1; ad_i = 32'hA; cbe_i = 4'h0;
        tick();
        par_i = ~ref_par(32'hA, 4'h0);
        ad_i = 32'hB; cbe_i = 4'h1;
        tick();
        rcv_data_i = 1'b0; par_i = ~ref_par(32'hB, 4'h1);
        chk("R10 first pulse", perr_n_o, 1'b0);
        tick();
        par_i = 1'b0;
        chk("R10 second pulse", perr_n_o, 1'b0);
        tick();
        chk("R10 released", perr_n_o, 1'b1);
        chk("R10 det", det_perr_o, 1'b1);
        clear_status();
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_source();
        t_receive_good();
        t_data_err();
        t_addr_err();
        t_sticky();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vecs++; errs++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule